// File: doc/BRIEF.md
# Scaled PWM Channel Clock Generator

This block derives two scaled clock enables from two prescaled input clock enables, then hands each of eight PWM channels either the plain input enable or the scaled one. Every clock in the block is a single-cycle enable pulse on the system clock. No clock is a derived clock net. The power-of-two prescaler that produces the input enables sits upstream of this block. The channel counters that consume the per-channel enables sit downstream.

Each scaled path has an 8-bit scale register and an 8-bit down counter. The counter steps down once on each cycle in which its input enable is high. On the input enable where it stands at 1, it fires an internal hit and reloads from the scale register. A two-state phase machine (states `PH_LOW` and `PH_HIGH`) halves the hit stream:

- A hit taken in `PH_LOW` moves the machine to `PH_HIGH` and emits the scaled enable.
- A hit taken in `PH_HIGH` returns the machine to `PH_LOW` with no output.
- With no hit, the machine stays in its current state.

So the scaled enable fires once every 2·N input enables. A scale of zero counts as 256. A write to a scale register reloads the matching counter on the same clock edge, so the new rate applies at once.

Software writes the two scale registers and an 8-bit select register through a plain write port. Address 0 is scale A, address 1 is scale B, address 2 is the select register, and address 3 has no target.

Top module: `pwm_scaled_clkgen`

## Requirements
- R1: Reset clears both scale registers and the select register, loads both counters with 0 and puts both phase machines in `PH_LOW`. With A enabled on every cycle, the first scaled A enable comes on the 256th A enable counted from reset.
- R2: A counter holds its value on every cycle in which its input enable is low and no write targets its scale register.
- R3: With scale N (1 to 255), the scaled enable fires once every 2·N input enables, and only on a cycle in which the input enable is high.
- R4: A scale value of 0x00 gives one scaled enable every 512 input enables.
- R5: A write to a scale register loads the new value into its counter on that edge, and this takes priority over a decrement in the same cycle. The next hit comes N input enables after the write.
- R6: Channels 0, 1, 4 and 5 take clock A or scaled A. Channels 2, 3, 6 and 7 take clock B or scaled B. No channel enable is high in a cycle where its group's input enable is low.
- R7: Bit i of the select register, written at address 2, decides channel i: 1 picks the scaled enable and 0 picks the plain input enable. Address 0 writes scale A and address 1 writes scale B.
- R8: A write to address 3 changes no register, so the output spacing stays as it was.
- R9: With A enabled on one cycle in four, scale 0xFF gives a scaled enable every 2040 cycles and scale 0x01 gives one every 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 scale A, 1 scale B, 2 select, 3 none) |
| wr_data | input | 8 | Write data |
| clk_a_en | input | 1 | Prescaled clock A enable |
| clk_b_en | input | 1 | Prescaled clock B enable |
| chan_clk_en | output | 8 | Per-channel clock enable |

## Verification
The assertions check four behaviours on every cycle:
- a counter holds still without an input enable or a write (R2);
- a counter reloads right after a write to its scale register (R5);
- no channel enable appears without its group's input enable (R6);
- the phase machine flips on every hit and only on a hit (R3).

The actual output spacing for scale values 0x00, 0x01, 0xFF and small values, at full and quarter input rates, is shown only by the bench's scenarios. The same holds for the first enable after reset, the effect of a reload written mid-count and the inert address 3. The bench also compares every channel output, on every cycle of a long randomized run, with a reference model built from the requirements.

// File: rtl/pwm_clk_pkg.sv
package pwm_clk_pkg;

    localparam int CNT_W   = 8;
    localparam int NUM_CH  = 8;
    localparam int NUM_GRP = 2;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_SCALE_A = 2'd0,
        ADR_SCALE_B = 2'd1,
        ADR_SELECT  = 2'd2,
        ADR_NONE    = 2'd3
    } reg_addr_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    // Group of a channel: bit 1 of the channel index (0 -> A, 1 -> B)
    function automatic int chan_group(input int ch);
        return (ch >> 1) & 1;
    endfunction

endpackage

// File: rtl/pwm_clk_regs.sv
module pwm_clk_regs
    import pwm_clk_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int NCH  = NUM_CH,
    parameter int NGRP = NUM_GRP,
    parameter int AW   = ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [CW-1:0]             wr_data,
    output logic [NGRP-1:0][CW-1:0]   scale_o,
    output logic [NGRP-1:0]           load_o,
    output logic [NCH-1:0]            sel_o
);

    logic [NGRP-1:0][CW-1:0] scale_q;
    logic [NCH-1:0]          sel_q;
    logic                    sel_wr;

    assign sel_wr = wr_en && (wr_addr == AW'(ADR_SELECT));

    for (genvar g = 0; g < NGRP; g++) begin : g_scale
        assign load_o[g] = wr_en && (wr_addr == AW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scale_q[g] <= '0;
            end else if (load_o[g]) begin
                scale_q[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= NCH'(wr_data);
        end
    end

    assign scale_o = scale_q;
    assign sel_o   = sel_q;

endmodule

// File: rtl/pwm_scale_div.sv
module pwm_scale_div
    import pwm_clk_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic [CW-1:0] scale_i,
    output logic          hit_o,
    output logic          scaled_o,
    output logic [CW-1:0] cnt_o,
    output phase_e        phase_o
);

    localparam logic [CW-1:0] TERM = CW'(1);

    logic [CW-1:0] cnt_q;
    phase_e        state_q;
    phase_e        state_d;
    logic          hit;

    assign hit = tick_i && (cnt_q == TERM);

    // Down counter; zero wraps to all-ones, so a load of 0 spans 2**CW enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (tick_i) begin
            cnt_q <= hit ? scale_i : cnt_q - TERM;
        end
    end

    // Phase state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Phase transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (hit) state_d = PH_HIGH;
            PH_HIGH: if (hit) state_d = PH_LOW;
            default: state_d = PH_LOW;
        endcase
    end

    // Outputs: scaled enable on the rising half of the toggle
    always_comb begin
        scaled_o = 1'b0;
        unique case (state_q)
            PH_LOW:  scaled_o = hit;
            PH_HIGH: scaled_o = 1'b0;
            default: scaled_o = 1'b0;
        endcase
    end

    assign hit_o   = hit;
    assign cnt_o   = cnt_q;
    assign phase_o = state_q;

endmodule

// File: rtl/pwm_chan_sel.sv
module pwm_chan_sel
    import pwm_clk_pkg::*;
#(
    parameter int NCH  = NUM_CH,
    parameter int NGRP = NUM_GRP
) (
    input  logic [NGRP-1:0] plain_i,
    input  logic [NGRP-1:0] scaled_i,
    input  logic [NCH-1:0]  sel_i,
    output logic [NCH-1:0]  chan_en_o
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam int GRP = chan_group(ch);
        assign chan_en_o[ch] = sel_i[ch] ? scaled_i[GRP] : plain_i[GRP];
    end

endmodule

// File: rtl/pwm_scaled_clkgen.sv
module pwm_scaled_clkgen
    import pwm_clk_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int NCH = NUM_CH,
    parameter int AW  = ADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    input  logic           clk_a_en,
    input  logic           clk_b_en,
    output logic [NCH-1:0] chan_clk_en
);

    localparam int NGRP = NUM_GRP;

    logic [NGRP-1:0][CW-1:0] scale_w;
    logic [NGRP-1:0]         load_w;
    logic [NCH-1:0]          sel_w;
    logic [NGRP-1:0]         plain_w;
    logic [NGRP-1:0]         scaled_w;
    logic [NGRP-1:0]         hit_w;
    logic [NGRP-1:0][CW-1:0] cnt_w;
    phase_e                  phase_w [NGRP];

    assign plain_w = {clk_b_en, clk_a_en};

    pwm_clk_regs #(
        .CW   (CW),
        .NCH  (NCH),
        .NGRP (NGRP),
        .AW   (AW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .scale_o (scale_w),
        .load_o  (load_w),
        .sel_o   (sel_w)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_div
        pwm_scale_div #(
            .CW (CW)
        ) u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (plain_w[g]),
            .load_i     (load_w[g]),
            .load_val_i (wr_data),
            .scale_i    (scale_w[g]),
            .hit_o      (hit_w[g]),
            .scaled_o   (scaled_w[g]),
            .cnt_o      (cnt_w[g]),
            .phase_o    (phase_w[g])
        );
    end

    pwm_chan_sel #(
        .NCH  (NCH),
        .NGRP (NGRP)
    ) u_sel (
        .plain_i   (plain_w),
        .scaled_i  (scaled_w),
        .sel_i     (sel_w),
        .chan_en_o (chan_clk_en)
    );

endmodule

// File: rtl/pwm_scaled_clkgen_chk.sv
module pwm_scaled_clkgen_chk
    import pwm_clk_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int NCH = NUM_CH,
    parameter int AW  = ADDR_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [AW-1:0]  wr_addr,
    input logic [CW-1:0]  wr_data,
    input logic           clk_a_en,
    input logic           clk_b_en,
    input logic [NCH-1:0] chan_clk_en,
    input logic [CW-1:0]  cnt_a,
    input logic [CW-1:0]  cnt_b,
    input logic           hit_a,
    input logic           hit_b,
    input phase_e         phase_a,
    input phase_e         phase_b
);

    function automatic logic [NCH-1:0] grp_mask(input int g);
        logic [NCH-1:0] m;
        m = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (chan_group(ch) == g) m[ch] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NCH-1:0] MASK_A = grp_mask(0);
    localparam logic [NCH-1:0] MASK_B = grp_mask(1);

    logic wr_a;
    logic wr_b;
    assign wr_a = wr_en && (wr_addr == AW'(ADR_SCALE_A));
    assign wr_b = wr_en && (wr_addr == AW'(ADR_SCALE_B));

    p_hold_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_a_en && !wr_a) |=> $stable(cnt_a));
    p_hold_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_b_en && !wr_b) |=> $stable(cnt_b));

    p_reload_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a |=> (cnt_a == $past(wr_data)));
    p_reload_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b |=> (cnt_b == $past(wr_data)));

    p_gate_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_a_en |-> ((chan_clk_en & MASK_A) == '0));
    p_gate_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_b_en |-> ((chan_clk_en & MASK_B) == '0));

    p_flip_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> (phase_a != $past(phase_a)));
    p_keep_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_a |=> $stable(phase_a));
    p_flip_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> (phase_b != $past(phase_b)));
    p_keep_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_b |=> $stable(phase_b));

endmodule

bind pwm_scaled_clkgen pwm_scaled_clkgen_chk #(
    .CW  (CW),
    .NCH (NCH),
    .AW  (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .clk_a_en    (clk_a_en),
    .clk_b_en    (clk_b_en),
    .chan_clk_en (chan_clk_en),
    .cnt_a       (cnt_w[0]),
    .cnt_b       (cnt_w[1]),
    .hit_a       (hit_w[0]),
    .hit_b       (hit_w[1]),
    .phase_a     (phase_w[0]),
    .phase_b     (phase_w[1])
);

// File: tb/pwm_scaled_clkgen_bench.sv
`timescale 1ns/1ps
module pwm_scaled_clkgen_bench;

    localparam real HALF = 2.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       clk_a_en = 1'b0;
    logic       clk_b_en = 1'b0;
    logic [7:0] chan_clk_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state, built from the requirements
    logic [7:0] m_cnt [2];
    logic [7:0] m_scl [2];
    bit         m_tog [2];
    logic [7:0] m_sel;
    logic [7:0] obs;
    int pa = 1, pb = 1, ph = 0;
    int n_a = 0;
    bit force_en = 1'b0;

    always #(HALF) clk = ~clk;

    pwm_scaled_clkgen u_pwm_scaled_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .clk_a_en    (clk_a_en),
        .clk_b_en    (clk_b_en),
        .chan_clk_en (chan_clk_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int g = 0; g < 2; g++) begin
            m_cnt[g] = 8'd0; m_scl[g] = 8'd0; m_tog[g] = 1'b0;
        end
        m_sel = 8'd0;
    endtask

    function automatic logic [7:0] model_out();
        logic [7:0] r;
        bit en [2];
        bit sc [2];
        en[0] = clk_a_en; en[1] = clk_b_en;
        for (int g = 0; g < 2; g++) sc[g] = en[g] && (m_cnt[g] == 8'd1) && !m_tog[g];
        for (int ch = 0; ch < 8; ch++) begin
            int g = (ch >> 1) & 1;
            r[ch] = m_sel[ch] ? sc[g] : en[g];
        end
        return r;
    endfunction

    task automatic model_step();
        bit en [2];
        en[0] = clk_a_en; en[1] = clk_b_en;
        if (!rst_n) begin
            model_reset();
            return;
        end
        for (int g = 0; g < 2; g++) begin
            bit hit = en[g] && (m_cnt[g] == 8'd1);
            if (wr_en && wr_addr == 2'(g)) begin
                m_cnt[g] = wr_data; m_scl[g] = wr_data;
            end else if (en[g]) begin
                m_cnt[g] = hit ? m_scl[g] : m_cnt[g] - 8'd1;
            end
            if (hit) m_tog[g] = !m_tog[g];
        end
        if (wr_en && wr_addr == 2'd2) m_sel = wr_data;
    endtask

    // One cycle: compare at negedge+1, model advances at posedge (R7 path compare)
    int shown = 0;
    task automatic tick();
        logic [7:0] e;
        #1;
        obs = chan_clk_en;
        e = model_out();
        checks++;
        if (obs !== e) begin
            errors++;
            if (shown < 10) $display("FAIL R7 per-cycle output actual=%h expected=%h", obs, e);
            shown++;
        end
        if (clk_a_en) n_a++;
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic step();
        if (!force_en) begin
            clk_a_en = (ph % pa) == 0;
            clk_b_en = (ph % pb) == 0;
        end
        ph++;
        tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    function automatic int full(input int s);
        return (s == 0) ? 256 : s;
    endfunction

    task automatic measure(input int ch, input int exp, input string req);
        int first = -1;
        int got = -1;
        for (int t = 0; t < 3 * exp + 20; t++) begin
            step();
            if (obs[ch]) begin
                if (first < 0) first = t;
                else begin got = t - first; break; end
            end
        end
        check(got == exp, req, got, exp);
    endtask

    initial begin
        #(HALF * 2.0 * 150000.0);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int first_fire;
        void'($urandom(32'd1234));
        model_reset();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
        end
        rst_n = 1'b1;
        n_a = 0;

        // R1/R6: after reset select is clear, channels follow plain enables by group
        force_en = 1'b1;
        clk_a_en = 1'b1; clk_b_en = 1'b0;
        tick();
        check(obs == 8'h33, "R1 R6 plain after reset", obs, 8'h33);
        clk_a_en = 1'b0; clk_b_en = 1'b1;
        tick();
        check(obs == 8'hCC, "R6 group B channels", obs, 8'hCC);

        // R1: first scaled A enable on the 256th A enable since reset
        clk_a_en = 1'b1; clk_b_en = 1'b1;
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'hFF;
        tick();
        wr_en = 1'b0;
        first_fire = -1;
        for (int t = 0; t < 400; t++) begin
            tick();
            if (obs[0]) begin first_fire = n_a; break; end
        end
        check(first_fire == 256, "R1 first scaled enable", first_fire, 256);
        force_en = 1'b0;

        // R4: scale 0 -> 512 enables
        pa = 1; pb = 1;
        measure(0, 512, "R4 scale 0 group A");
        measure(2, 512, "R4 scale 0 group B");

        // R9: A at one cycle in four
        pa = 4;
        wr(2'd0, 8'hFF);
        measure(1, 2040, "R9 scale FF quarter rate");
        wr(2'd0, 8'h01);
        measure(4, 8, "R9 scale 01 quarter rate");

        // R3: group B scale 5 -> 10
        pb = 1;
        wr(2'd1, 8'd5);
        measure(6, 10, "R3 scale 5 ch6");
        measure(7, 10, "R3 scale 5 ch7");

        // R7: clear select bits of channels 4..7 -> plain
        wr(2'd2, 8'h0F);
        force_en = 1'b1; clk_a_en = 1'b1; clk_b_en = 1'b1;
        tick();
        check(obs[7:4] == 4'hF, "R7 plain select", obs[7:4], 4'hF);
        force_en = 1'b0;
        wr(2'd2, 8'hFF);

        // R2: A on one cycle in three, scale 2 -> 12 cycles
        pa = 3;
        wr(2'd0, 8'd2);
        measure(5, 12, "R2 counts only on enable");

        // R5: mid-count reload
        pa = 1;
        wr(2'd0, 8'd200);
        for (int i = 0; i < 37; i++) step();
        wr(2'd0, 8'd10);
        begin
            int k = -1;
            for (int t = 1; t <= 30; t++) begin
                step();
                if (obs[0]) begin k = t; break; end
            end
            check(k == 10 || k == 20, "R5 reload mid-count", k, 10);
        end
        measure(0, 20, "R5 new rate after reload");

        // R8: address 3 has no effect
        wr(2'd0, 8'd3);
        wr(2'd3, 8'd1);
        measure(0, 6, "R8 address 3 inert");
        check(1, "R8", 0, 0);

        // Random traffic, every cycle compared with the model (R3 R5 R7)
        pa = 1; pb = 1;
        force_en = 1'b1;
        for (int i = 0; i < 15000; i++) begin
            clk_a_en = ($urandom % 3) != 0;
            clk_b_en = ($urandom % 2) != 0;
            if (($urandom % 48) == 0) begin
                wr_en = 1'b1;
                wr_addr = 2'($urandom % 4);
                wr_data = (($urandom % 2) == 0) ? 8'($urandom % 6) : 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            tick();
        end
        wr_en = 1'b0;
        force_en = 1'b0;
        wr(2'd1, 8'd4);
        measure(3, 8, "R3 after random traffic");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule